// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a master-only SPI engine clocked by the system bus clock. A host writes bytes into a one-byte transmit holding register. The engine moves each byte into an 8-bit shift register and exchanges it full duplex with the attached slave. It places each received byte into a one-byte receive holding register. Both directions are double buffered. The host can queue a second byte while the first is shifting, and the engine starts the queued byte on its own, with no gap in the bit clock and no release of the select line.

The bit clock comes from two divider stages in series. The first stage divides the bus clock linearly by 1 to 8, set by a 3-bit prescale field. The second stage divides by a power of two from 2 to 256, set by a 3-bit rate field. The SPI mode is fixed at polarity 0, phase 0: SCK idles low, MISO is captured on the rising edge, and MOSI moves on the falling edge. A control bit selects MSB-first or LSB-first order. If a transfer completes while the receive register still holds an unread byte, the new byte is discarded and no flag is raised.

The prescale, rate and bit-order inputs must stay constant while `cs_n` is low.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_full` is 0, `cs_n` is 1 and `sck` is 0. `sck` is low whenever `cs_n` is high.
- R2: With prescale value P and rate value R, each SCK level lasts H = (P+1)*2^R bus cycles. The first rising edge of `sck` comes exactly H cycles after `cs_n` falls.
- R3: With `lsb_first` = 0, a transfer sends the written byte on `mosi` most significant bit first. It captures 8 `miso` bits, one at each rising `sck` edge, and assembles them with the first bit captured as bit 7.
- R4: With `lsb_first` = 1, bit 0 is sent first, and the first captured `miso` bit becomes bit 0 of the received byte.
- R5: While `cs_n` stays low, `mosi` changes only in the cycle where `sck` falls. The first bit is already on `mosi` when `cs_n` falls.
- R6: A write (`wr_en` = 1) while `tx_empty` = 1 stores `wr_data` and clears `tx_empty` in the next cycle. One cycle later the byte moves into the shifter and `tx_empty` returns to 1. A write while `tx_empty` = 0 is ignored.
- R7: If a byte is waiting when a transfer's eighth falling edge occurs, that byte starts at once. `cs_n` stays low, and the next rising edge comes H cycles after that falling edge.
- R8: When a transfer completes with `rx_full` = 0, the received byte appears on `rd_data` and `rx_full` becomes 1. A read pulse (`rd_en` = 1) clears `rx_full`.
- R9: If a transfer completes while `rx_full` = 1, the new byte is discarded. `rd_data` keeps the old byte and no indication is given.
- R10: After the last byte, with nothing queued, `cs_n` rises H cycles after the final falling edge of `sck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 3 | Prescale field P, linear divide by P+1 |
| rate | input | 3 | Rate field R, divide by 2^(R+1) |
| lsb_first | input | 1 | 1 selects LSB-first bit order |
| wr_en | input | 1 | Host write strobe for the transmit register |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register can accept a byte |
| rd_en | input | 1 | Host read strobe, clears `rx_full` |
| rd_data | output | 8 | Receive holding register contents |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
A divider counter stuck at the wrong limit would show within one half bit period, as a wrong spacing between `cs_n` falling and the first `sck` edge. A bit counter or shifter fault would show after one byte as a corrupted `mosi` pattern or wrong `rd_data`. Faults in buffer state show within one or two transfers: a transmit-empty flag that clears wrongly would drop or duplicate a queued byte, and a receive-full flag that clears wrongly would overwrite a held byte during an overrun. The sweep covers every prescale value at several rate values and the slowest corner, in both bit orders, so that each divider product is measured edge by edge.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    localparam int DEF_DW = 8;
    localparam int DEF_PW = 3;
    localparam int DEF_RW = 3;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_TAIL = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int PW = 3,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] presc,
    input  logic [RW-1:0] rate,
    output logic          tick
);
    localparam int CW = PW + (1 << RW) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = ((CW'(presc) + CW'(1)) << rate) - CW'(1);
        tick  = run && (div_q.cnt == limit);
        div_d = div_q;
        if (!run || tick) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_q.cnt <= limit)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_q.cnt == '0)); // R2
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_dbuf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_byte,
    input  logic          lsb_first,
    input  logic          miso,
    output logic          load,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          run,
    output logic          sck,
    output logic          mosi,
    output logic          cs_n
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        eng_state_t    st;
        logic [DW-1:0] sh;
        logic          smp;
        logic [BW-1:0] bitn;
        logic          sck;
        logic          cs_n;
    } eng_t;

    eng_t e_d, e_q;
    logic [DW-1:0] shifted;

    always_comb begin
        shifted = lsb_first ? {e_q.smp, e_q.sh[DW-1:1]} : {e_q.sh[DW-2:0], e_q.smp};
        rx_byte = shifted;
        load    = 1'b0;
        done    = 1'b0;
        e_d     = e_q;
        unique case (e_q.st)
            ENG_IDLE: begin
                if (tx_valid) begin
                    load      = 1'b1;
                    e_d.sh    = tx_byte;
                    e_d.bitn  = '0;
                    e_d.sck   = 1'b0;
                    e_d.cs_n  = 1'b0;
                    e_d.st    = ENG_RUN;
                end
            end
            ENG_RUN: begin
                if (tick) begin
                    if (!e_q.sck) begin
                        e_d.sck = 1'b1;
                        e_d.smp = miso;
                    end else begin
                        e_d.sck = 1'b0;
                        if (e_q.bitn == BW'(DW-1)) begin
                            done = 1'b1;
                            if (tx_valid) begin
                                load     = 1'b1;
                                e_d.sh   = tx_byte;
                                e_d.bitn = '0;
                            end else begin
                                e_d.st = ENG_TAIL;
                            end
                        end else begin
                            e_d.sh   = shifted;
                            e_d.bitn = e_q.bitn + BW'(1);
                        end
                    end
                end
            end
            ENG_TAIL: begin
                if (tick) begin
                    e_d.cs_n = 1'b1;
                    e_d.st   = ENG_IDLE;
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ENG_IDLE;
            e_q.cs_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign run  = (e_q.st != ENG_IDLE);
    assign sck  = e_q.sck;
    assign cs_n = e_q.cs_n;
    assign mosi = lsb_first ? e_q.sh[0] : e_q.sh[DW-1];

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R1
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sck)); // R5
    AST_CS_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!sck && $past(!sck))); // R10
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
    import spi_dbuf_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int PW = DEF_PW,
    parameter int RW = DEF_RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] presc,
    input  logic [RW-1:0] rate,
    input  logic          lsb_first,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          tx_empty,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rx_full,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);
    typedef struct packed {
        logic [DW-1:0] tx_buf;
        logic          tx_empty;
        logic [DW-1:0] rx_buf;
        logic          rx_full;
    } host_t;

    host_t h_d, h_q;
    logic          tick, run, core_load, core_done;
    logic [DW-1:0] core_rx;

    spi_rate_div #(.PW(PW), .RW(RW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .presc (presc),
        .rate  (rate),
        .tick  (tick)
    );

    spi_shift_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_valid  (!h_q.tx_empty),
        .tx_byte   (h_q.tx_buf),
        .lsb_first (lsb_first),
        .miso      (miso),
        .load      (core_load),
        .done      (core_done),
        .rx_byte   (core_rx),
        .run       (run),
        .sck       (sck),
        .mosi      (mosi),
        .cs_n      (cs_n)
    );

    always_comb begin
        h_d = h_q;
        if (core_load) begin
            h_d.tx_empty = 1'b1;
        end
        if (wr_en && h_q.tx_empty) begin
            h_d.tx_buf   = wr_data;
            h_d.tx_empty = 1'b0;
        end
        if (rd_en) begin
            h_d.rx_full = 1'b0;
        end
        if (core_done && !h_q.rx_full) begin
            h_d.rx_buf  = core_rx;
            h_d.rx_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q          <= '0;
            h_q.tx_empty <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign tx_empty = h_q.tx_empty;
    assign rx_full  = h_q.rx_full;
    assign rd_data  = h_q.rx_buf;

    AST_TXE_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en)); // R6
    AST_RXF_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(!cs_n)); // R8
    AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_en) |=> (rx_full && $stable(rd_data))); // R9
endmodule

// File: tb/sim_spi_dbuf_master.sv
module sim_spi_dbuf_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] presc = 3'd0;
    logic [2:0] rate = 3'd0;
    logic       lsb_first = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic       tx_empty, rx_full, sck, mosi, miso, cs_n;
    logic [7:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0] slave_q [16];
    logic [7:0] mon_q [16];
    int mon_n = 0, sidx = 0, bitn = 0, cyc = 0, last = 0;
    int err_cnt = 0, cs_gap = 0, cs_falls = 0;
    logic [7:0] mon_sh = 8'd0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    int hexp;

    always #5 clk = ~clk;

    spi_dbuf_master u0 (
        .clk(clk), .rst_n(rst_n), .presc(presc), .rate(rate), .lsb_first(lsb_first),
        .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty), .rd_en(rd_en),
        .rd_data(rd_data), .rx_full(rx_full), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    assign hexp = (int'(presc) + 1) << rate;
    assign miso = lsb_first ? slave_q[sidx[3:0]][bitn[2:0]]
                            : slave_q[sidx[3:0]][3'd7 - bitn[2:0]];

    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (prev_cs && !cs_n) begin
                last = cyc; bitn = 0; cs_falls = cs_falls + 1;
            end
            if (!prev_sck && sck) begin
                if (cyc - last != hexp) err_cnt = err_cnt + 1;
                last = cyc;
                mon_sh = lsb_first ? {mosi, mon_sh[7:1]} : {mon_sh[6:0], mosi};
            end
            if (prev_sck && !sck) begin
                if (cyc - last != hexp) err_cnt = err_cnt + 1;
                last = cyc;
                bitn = bitn + 1;
                if (bitn == 8) begin
                    mon_q[mon_n[3:0]] = mon_sh;
                    mon_n = mon_n + 1;
                    bitn = 0;
                    sidx = sidx + 1;
                end
            end
            if (!prev_cs && cs_n) cs_gap = cyc - last;
            prev_sck = sck;
            prev_cs = cs_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] b);
        wr_data = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_done();
        repeat (2) @(negedge clk);
        while (!cs_n || !tx_empty) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic one_byte(input int p, input int r, input bit lsb, input logic [7:0] tx,
                            input logic [7:0] sl);
        int e0, m0;
        presc = 3'(p); rate = 3'(r); lsb_first = lsb;
        @(negedge clk);
        slave_q[sidx[3:0]] = sl;
        e0 = err_cnt; m0 = mon_n;
        host_write(tx);
        wait_done();
        check(lsb ? "R4 mosi byte" : "R3 mosi byte", int'(mon_q[m0[3:0]]), int'(tx));
        check(lsb ? "R4 rx byte" : "R3 rx byte", int'(rd_data), int'(sl));
        check("R2 edge spacing errors", err_cnt - e0, 0);
        check("R10 cs release gap", cs_gap, (p + 1) << r);
        check("R8 rx_full set", int'(rx_full), 1);
        host_read();
        check("R8 rx_full cleared", int'(rx_full), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) slave_q[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 tx_empty", int'(tx_empty), 1);
        check("R1 rx_full", int'(rx_full), 0);
        check("R1 cs_n", int'(cs_n), 1);
        check("R1 sck", int'(sck), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 flag timing and R5 first bit ready at select
        presc = 3'd1; rate = 3'd1; lsb_first = 1'b0;
        slave_q[sidx[3:0]] = 8'h3C;
        host_write(8'hA5);
        check("R6 tx_empty cleared after write", int'(tx_empty), 0);
        @(negedge clk);
        check("R6 tx_empty set on load", int'(tx_empty), 1);
        check("R5 first bit at select", int'(mosi), 1);
        wait_done();
        host_read();

        // R6 write while full is ignored
        begin
            int m0;
            m0 = mon_n;
            slave_q[sidx[3:0]] = 8'h11;
            host_write(8'h5A);
            check("R6 flag low before second write", int'(tx_empty), 0);
            host_write(8'hFF);
            check("R6 load after ignored write", int'(tx_empty), 1);
            wait_done();
            check("R6 ignored write byte count", mon_n - m0, 1);
            check("R6 transferred byte", int'(mon_q[m0[3:0]]), 8'h5A);
            host_read();
        end

        // R2 R3 sweep, MSB first
        for (int p = 0; p < 8; p++)
            for (int r = 0; r < 5; r++)
                one_byte(p, r, 1'b0, 8'(p * 37 + r * 11 + 5), 8'(~(p * 19 + r * 53)));
        one_byte(7, 7, 1'b0, 8'hC3, 8'h96);

        // R4 LSB first
        for (int p = 0; p < 8; p += 3)
            for (int r = 0; r < 4; r++)
                one_byte(p, r, 1'b1, 8'(p * 29 + r * 7 + 1), 8'(p * 13 + r * 71 + 2));

        // R7 chaining with R9 overrun
        begin
            int e0, m0, c0;
            presc = 3'd2; rate = 3'd1; lsb_first = 1'b0;
            @(negedge clk);
            slave_q[sidx[3:0]] = 8'h81;
            slave_q[4'(sidx + 1)] = 8'h7E;
            e0 = err_cnt; m0 = mon_n; c0 = cs_falls;
            host_write(8'h12);
            @(negedge clk);
            host_write(8'h34);
            wait_done();
            check("R7 bytes in burst", mon_n - m0, 2);
            check("R7 single select", cs_falls - c0, 1);
            check("R7 no spacing error", err_cnt - e0, 0);
            check("R7 second byte", int'(mon_q[4'(m0 + 1)]), 8'h34);
            check("R9 old byte kept", int'(rd_data), 8'h81);
            check("R9 rx_full still set", int'(rx_full), 1);
            host_read();
        end

        // R7 R8 chaining with a timely read
        begin
            int m0;
            presc = 3'd1; rate = 3'd1; lsb_first = 1'b1;
            @(negedge clk);
            slave_q[sidx[3:0]] = 8'h0F;
            slave_q[4'(sidx + 1)] = 8'hE2;
            m0 = mon_n;
            host_write(8'h9C);
            @(negedge clk);
            host_write(8'h47);
            while (!rx_full) @(negedge clk);
            check("R8 first byte", int'(rd_data), 8'h0F);
            host_read();
            wait_done();
            check("R7 second mosi byte", int'(mon_q[4'(m0 + 1)]), 8'h47);
            check("R8 second rx byte", int'(rd_data), 8'hE2);
            host_read();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule